// File: doc/BRIEF.md
# External Reference Clock Loss Monitor

This block watches a slow external clock that is meant to drive a real-time counter and decides whether that clock may be trusted. A two-bit rate select names the expected rate. The block measures each period of the incoming clock against a fast local reference whose frequency is a parameter. A period is accepted when its length is within 0.8 % of the nominal length for the selected rate. An input that stops toggling is also caught, by a timeout.

The block has two outputs. The first is a level request that the loss flag be set; it goes into a status register outside the block. The second is a status bit that is high while the external clock is valid to condition the counter. When software clears the loss flag while the input frequency is still wrong, the register sends a one-cycle clear notice. Frequency-deviation reports are then masked until the rate select or the enable changes, or the block is reset. All other rules stay active.

Top module: `refclk_loss_monitor`

## Requirements
- R1: The rate select encodes 0 = 1 Hz, 1 = 50 Hz, 2 = 60 Hz and 3 = 32.768 kHz (the rates are parameters). A period of N reference cycles between input rising edges is accepted when nominal − tol ≤ N ≤ nominal + tol, where nominal = round(REF_HZ / rate) and tol = floor(nominal × 0.8 %). `ext_ok_o` rises only after such an accepted period.
- R2: While the enable input is 0, `los_req_o` is 1 and `ext_ok_o` is 0, whatever the input clock does.
- R3: When no rising edge arrives within nominal + tol reference cycles of the last one, `los_req_o` is raised and `ext_ok_o` drops. The condition clears only after a complete accepted period.
- R4: A completed period outside the window raises `los_req_o` and lowers `ext_ok_o`.
- R5: A clear notice (`flag_clr_i` high for a cycle) that arrives while the last period was out of tolerance masks later deviation reports. A clear notice that arrives while the frequency is good has no such effect.
- R6: The mask from R5 is removed by a change of the rate select, a change of the enable, or a reset.
- R7: A change of the select or the enable restarts measurement. The interval up to the first rising edge after the change is not judged. `ext_ok_o` stays 0 until one complete accepted period has been seen.
- R8: After reset the select reads as 0, the enable reads as 0, `los_req_o` is 1 and `ext_ok_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast local reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_clk_i | input | 1 | External clock under test (asynchronous) |
| ext_en_i | input | 1 | Enable for the external clock path |
| rate_sel_i | input | 2 | Expected rate select |
| flag_clr_i | input | 1 | One-cycle notice that the loss flag was cleared |
| los_req_o | output | 1 | Request to set the loss-of-signal flag |
| ext_ok_o | output | 1 | External clock currently conditions the counter |

## Verification
On every cycle the assertions check the following: a disabled path requests loss on the next cycle; a timeout marks the clock as stopped; a bad period or a restart removes the valid status; the valid status rises only directly after an accepted period; the deviation mask appears only after a clear notice and is dropped by a restart. Only the bench scenarios can show the window edges, because that needs exact period lengths just inside and just outside the bounds for each select code. The same holds for the mask hiding a deviation but not a stall, for a clear during good frequency leaving later reports active, and for the discarded partial interval after a restart.

// File: rtl/rlm_pkg.sv
package rlm_pkg;

   localparam longint unsigned PPM = 64'd1_000_000;

   function automatic longint unsigned nom_cnt(longint unsigned ref_hz, longint unsigned rate_mhz);
      return (ref_hz * 64'd1000 + rate_mhz / 2) / rate_mhz;
   endfunction

   function automatic longint unsigned tol_cnt(longint unsigned ref_hz, longint unsigned rate_mhz,
                                               longint unsigned tol_ppm);
      return nom_cnt(ref_hz, rate_mhz) * tol_ppm / PPM;
   endfunction

   function automatic longint unsigned lo_cnt(longint unsigned ref_hz, longint unsigned rate_mhz,
                                              longint unsigned tol_ppm);
      return nom_cnt(ref_hz, rate_mhz) - tol_cnt(ref_hz, rate_mhz, tol_ppm);
   endfunction

   function automatic longint unsigned hi_cnt(longint unsigned ref_hz, longint unsigned rate_mhz,
                                              longint unsigned tol_ppm);
      return nom_cnt(ref_hz, rate_mhz) + tol_cnt(ref_hz, rate_mhz, tol_ppm);
   endfunction

   function automatic longint unsigned max4(longint unsigned a, longint unsigned b,
                                            longint unsigned c, longint unsigned d);
      longint unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/rlm_sync_edge.sv
module rlm_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic rise_o
);
   logic [STAGES-1:0] stage_q;
   logic              last_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("rlm_sync_edge: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[0] <= 1'b0;
            else         stage_q[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[g] <= 1'b0;
            else         stage_q[g] <= stage_q[g-1];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) last_q <= 1'b0;
      else         last_q <= stage_q[STAGES-1];
   end

   assign rise_o = stage_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/rlm_period_meter.sv
module rlm_period_meter
   import rlm_pkg::*;
#(
   parameter longint unsigned REF_HZ      = 64'd32_768_000,
   parameter longint unsigned RATE_MHZ [4] = '{64'd1000, 64'd50_000, 64'd60_000, 64'd32_768_000},
   parameter longint unsigned TOL_PPM     = 64'd8000,
   parameter int unsigned     CNT_W       = 26
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       rise_i,
   input  logic       en_i,
   input  logic       restart_i,
   input  logic [1:0] sel_i,
   output logic       done_o,
   output logic       in_tol_o,
   output logic       overdue_o
);
   localparam int unsigned NSEL = 4;

   logic [CNT_W-1:0] lo_tab [NSEL];
   logic [CNT_W-1:0] hi_tab [NSEL];
   logic [CNT_W-1:0] cnt_q, meas, lo_sel, hi_sel;
   logic             armed_q, live;

   for (genvar g = 0; g < NSEL; g++) begin : g_bounds
      localparam longint unsigned LO = lo_cnt(REF_HZ, RATE_MHZ[g], TOL_PPM);
      localparam longint unsigned HI = hi_cnt(REF_HZ, RATE_MHZ[g], TOL_PPM);
      if (LO < 2) begin : g_bad_lo
         $error("rlm_period_meter: reference too slow for rate %0d", g);
      end
      if (HI + 1 >= (64'd1 << CNT_W)) begin : g_bad_w
         $error("rlm_period_meter: CNT_W too small for rate %0d", g);
      end
      assign lo_tab[g] = CNT_W'(LO);
      assign hi_tab[g] = CNT_W'(HI);
   end

   assign lo_sel = lo_tab[sel_i];
   assign hi_sel = hi_tab[sel_i];
   assign live   = en_i & ~restart_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (!live) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (rise_i) begin
         cnt_q   <= '0;
         armed_q <= 1'b1;
      end else if (cnt_q != '1) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign meas      = cnt_q + 1'b1;
   assign done_o    = live & rise_i & armed_q;
   assign in_tol_o  = (meas >= lo_sel) && (meas <= hi_sel);
   assign overdue_o = live & ~rise_i & (cnt_q >= hi_sel);

endmodule

// File: rtl/rlm_status.sv
module rlm_status (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       en_i,
   input  logic [1:0] sel_i,
   input  logic       clr_i,
   input  logic       done_i,
   input  logic       in_tol_i,
   input  logic       overdue_i,
   output logic       en_q_o,
   output logic [1:0] sel_q_o,
   output logic       restart_o,
   output logic       los_o,
   output logic       ok_o
);
   logic       en_q, stopped_q, good_q, dev_q, inhib_q;
   logic [1:0] sel_q;

   assign restart_o = (en_i != en_q) || (sel_i != sel_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q      <= 1'b0;
         sel_q     <= 2'd0;
         stopped_q <= 1'b0;
         good_q    <= 1'b0;
         dev_q     <= 1'b0;
         inhib_q   <= 1'b0;
      end else if (restart_o) begin
         en_q      <= en_i;
         sel_q     <= sel_i;
         stopped_q <= 1'b0;
         good_q    <= 1'b0;
         dev_q     <= 1'b0;
         inhib_q   <= 1'b0;
      end else if (en_q) begin
         if (done_i) begin
            if (in_tol_i) begin
               good_q    <= 1'b1;
               dev_q     <= 1'b0;
               stopped_q <= 1'b0;
            end else begin
               good_q    <= 1'b0;
               dev_q     <= 1'b1;
            end
         end else if (overdue_i) begin
            stopped_q <= 1'b1;
            good_q    <= 1'b0;
         end
         if (clr_i && dev_q) inhib_q <= 1'b1;
      end
   end

   assign en_q_o  = en_q;
   assign sel_q_o = sel_q;
   assign los_o   = ~en_q | stopped_q | (dev_q & ~inhib_q);
   assign ok_o    = en_q & good_q & ~stopped_q;

   a_r3_timeout_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      overdue_i |=> stopped_q);
   a_r4_bad_period_drops_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_i && !in_tol_i) |=> !ok_o);
   a_r1_ok_after_accepted: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ok_o) |-> $past(done_i && in_tol_i));
   a_r5_mask_needs_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(inhib_q) |-> $past(clr_i));
   a_r6_restart_unmasks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_o |=> !inhib_q);
   a_r7_restart_clears_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_o |=> !ok_o);

endmodule

// File: rtl/refclk_loss_monitor.sv
module refclk_loss_monitor
   import rlm_pkg::*;
#(
   parameter longint unsigned REF_HZ       = 64'd32_768_000,
   parameter longint unsigned RATE_MHZ [4] = '{64'd1000, 64'd50_000, 64'd60_000, 64'd32_768_000},
   parameter longint unsigned TOL_PPM      = 64'd8000,
   parameter int unsigned     SYNC_STAGES  = 2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       ext_clk_i,
   input  logic       ext_en_i,
   input  logic [1:0] rate_sel_i,
   input  logic       flag_clr_i,
   output logic       los_req_o,
   output logic       ext_ok_o
);
   localparam longint unsigned MAX_HI = max4(hi_cnt(REF_HZ, RATE_MHZ[0], TOL_PPM),
                                             hi_cnt(REF_HZ, RATE_MHZ[1], TOL_PPM),
                                             hi_cnt(REF_HZ, RATE_MHZ[2], TOL_PPM),
                                             hi_cnt(REF_HZ, RATE_MHZ[3], TOL_PPM));
   localparam int unsigned CNT_W = $clog2(MAX_HI + 2);

   if (TOL_PPM >= PPM) begin : g_bad_tol
      $error("refclk_loss_monitor: TOL_PPM out of range");
   end

   logic       rise, done, in_tol, overdue, restart, en_q;
   logic [1:0] sel_q;

   rlm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .async_i(ext_clk_i), .rise_o(rise));

   rlm_period_meter #(
      .REF_HZ(REF_HZ), .RATE_MHZ(RATE_MHZ), .TOL_PPM(TOL_PPM), .CNT_W(CNT_W)
   ) u_meter (
      .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .en_i(en_q),
      .restart_i(restart), .sel_i(sel_q),
      .done_o(done), .in_tol_o(in_tol), .overdue_o(overdue));

   rlm_status u_status (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(ext_en_i), .sel_i(rate_sel_i),
      .clr_i(flag_clr_i), .done_i(done), .in_tol_i(in_tol), .overdue_i(overdue),
      .en_q_o(en_q), .sel_q_o(sel_q), .restart_o(restart),
      .los_o(los_req_o), .ok_o(ext_ok_o));

   a_r2_disabled_requests_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ext_en_i |=> los_req_o);
   a_r8_ok_implies_no_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ext_ok_o |-> !los_req_o);

endmodule

// File: tb/tb_refclk_loss_monitor.sv
module tb_refclk_loss_monitor;
   // Scaled rates: 1 MHz reference; select 0..3 -> nominal 1000, 500, 250, 100 cycles,
   // tolerance 8, 4, 2, 0 cycles.
   logic clk = 1'b0, rst_n = 1'b0, ext = 1'b0, en = 1'b0, clr = 1'b0;
   logic [1:0] sel = 2'd0;
   logic los, ok;
   int n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   refclk_loss_monitor #(
      .REF_HZ(64'd1_000_000),
      .RATE_MHZ('{64'd1_000_000, 64'd2_000_000, 64'd4_000_000, 64'd10_000_000}),
      .TOL_PPM(64'd8000), .SYNC_STAGES(2)
   ) dut (
      .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext), .ext_en_i(en),
      .rate_sel_i(sel), .flag_clr_i(clr), .los_req_o(los), .ext_ok_o(ok));

   localparam int NV = 13;
   localparam int V_SEL [NV] = '{3, 3, 2, 2, 2, 2, 2, 1, 1, 1, 0, 0, 0};
   localparam int V_PER [NV] = '{100, 101, 250, 252, 253, 248, 247, 500, 504, 505, 1000, 992, 991};
   localparam int V_LOS [NV] = '{0, 1, 0, 0, 1, 0, 1, 0, 0, 1, 0, 0, 1};

   task automatic chk(string req, logic act, logic exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic run_ext(int p, int n);
      for (int i = 0; i < n; i++) begin
         ext = 1'b1;
         repeat (p / 2) @(negedge clk);
         ext = 1'b0;
         repeat (p - p / 2) @(negedge clk);
      end
   endtask

   task automatic pulse_clr();
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (150_000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R8", los, 1'b1, "loss after reset");
      chk("R8", ok, 1'b0, "ok after reset");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8", los, 1'b1, "loss with enable low");

      // R1 / R4: window edges for every select code
      en = 1'b1;
      for (int v = 0; v < NV; v++) begin
         sel = 2'(V_SEL[v]);
         run_ext(V_PER[v], 4);
         chk(V_LOS[v] != 0 ? "R4" : "R1", los, 1'(V_LOS[v]), $sformatf("loss vec %0d", v));
         chk(V_LOS[v] != 0 ? "R4" : "R1", ok, 1'(V_LOS[v] == 0), $sformatf("ok vec %0d", v));
      end

      // R2: disabled path with a good clock
      sel = 2'd3;
      run_ext(100, 4);
      en = 1'b0;
      run_ext(100, 3);
      chk("R2", los, 1'b1, "loss while disabled");
      chk("R2", ok, 1'b0, "ok while disabled");
      en = 1'b1;
      run_ext(100, 4);
      chk("R2", ok, 1'b1, "ok after re-enable");

      // R3: stalled input, then recovery
      ext = 1'b0;
      repeat (150) @(negedge clk);
      chk("R3", los, 1'b1, "loss on stall");
      chk("R3", ok, 1'b0, "ok on stall");
      run_ext(100, 3);
      chk("R3", los, 1'b0, "loss cleared after good period");
      chk("R3", ok, 1'b1, "ok after good period");

      // R7: partial interval after restart is not judged
      sel = 2'd2;
      repeat (37) @(negedge clk);
      ext = 1'b1;
      repeat (60) @(negedge clk);
      chk("R7", los, 1'b0, "partial interval judged");
      chk("R7", ok, 1'b0, "ok before complete period");
      repeat (65) @(negedge clk);
      ext = 1'b0;
      repeat (125) @(negedge clk);
      run_ext(250, 2);
      chk("R7", ok, 1'b1, "ok after complete period");

      // R5: clear while frequency bad masks deviation
      run_ext(240, 3);
      chk("R4", los, 1'b1, "short period loss");
      pulse_clr();
      run_ext(240, 3);
      chk("R5", los, 1'b0, "deviation masked after clear");
      chk("R5", ok, 1'b0, "ok while masked");
      ext = 1'b0;
      repeat (300) @(negedge clk);
      chk("R5", los, 1'b1, "stall not masked");

      // R6: select change releases the mask
      sel = 2'd1;
      run_ext(490, 4);
      chk("R6", los, 1'b1, "mask released by select change");

      // R5: clear while frequency good does not mask
      run_ext(500, 4);
      chk("R5", los, 1'b0, "good before clear");
      pulse_clr();
      run_ext(490, 4);
      chk("R5", los, 1'b1, "no mask from clear while good");

      // R6: enable toggle releases the mask
      pulse_clr();
      run_ext(490, 3);
      chk("R5", los, 1'b0, "masked again");
      en = 1'b0;
      @(negedge clk);
      en = 1'b1;
      run_ext(490, 4);
      chk("R6", los, 1'b1, "mask released by enable change");

      // R6: reset releases the mask
      pulse_clr();
      run_ext(490, 3);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R8", los, 1'b1, "loss in mid-run reset");
      rst_n = 1'b1;
      sel = 2'd1;
      run_ext(490, 4);
      chk("R6", los, 1'b1, "mask released by reset");

      summary();
      $finish;
   end

endmodule